// File: doc/BRIEF.md
# Periodic Down-Counting Interrupt Timer

This block is a 32-bit down counter that raises a level interrupt each time it runs out. Software reaches it through a small word-addressed register port: one write strobe, a word index, write data and a combinational read path. Counting is paced by one of two tick-enable inputs, a fast one and a slow one, which the clock-source field selects. The selected tick is divided by a 12-bit prescaler held in the control register.

When the counter steps while it holds zero, a sticky status flag is set. The counter then either reloads from the load register or wraps to all-ones, as set by a mode bit. The interrupt output follows the status flag, gated by an interrupt-enable bit. Software clears the flag by writing anything to the status word. An overwrite option makes writes to the load register also replace the running count. A software-reset bit in the control word returns the block to its reset state before the rest of that control write takes effect. The compare word is plain storage; it has no effect on counting.

Top module: `pdt_top`

## Requirements
- R1: After reset, control, status and compare read 0, load and counter read 0xFFFFFFFF, and the interrupt is low.
- R2: The word indices are control 0, status 1 (flag in bit 0), load 2, compare 3, counter 4. Control keeps written bits 25:0, and its bit 16 always reads 0. Writes to index 4 and to indices 5..7 change nothing, and reads of 5..7 return 0.
- R3: Control bits 25:24 pick the tick. 00 stops counting, 01 and 10 use the fast tick, and 11 uses the slow tick. The counter is also held while control bit 0 (enable) is 0.
- R4: With prescaler value P (control bits 15:4), the counter steps once per P+1 selected ticks. The prescaler phase restarts whenever the timer is stopped, so the first step after starting comes after a full P+1 ticks.
- R5: A control write that leaves enable at 1 with a non-zero clock source loads the counter from the load register when bit 1 (keep mode) is 0. When bit 1 is 1, the count is left as it was.
- R6: A step from a non-zero count decrements it. A step at zero sets the status flag, and with bit 3 (reload mode) at 1 the counter takes the load value.
- R7: With reload mode at 0, a step at zero sets the status flag and the counter becomes 0xFFFFFFFF.
- R8: Any write to the status word clears the flag. If an expiry happens in the same cycle, the flag ends up set.
- R9: The interrupt output is high exactly when the status flag is 1 and control bit 2 (interrupt enable) is 1.
- R10: With control bit 17 (overwrite) at 1, a load write also replaces the counter with the written value. With it at 0, the counter is unaffected.
- R11: A control write with bit 16 set first clears status and compare and sets load and counter to 0xFFFFFFFF, then stores the written control value.
- R12: Compare writes are stored and read back and never alter counting or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| tick_fast | input | 1 | Fast count enable |
| tick_slow | input | 1 | Slow count enable |
| irq | output | 1 | Level interrupt |

## Verification
Two collisions matter most. The first is a status-clear write in the cycle where the counter expires. The second is a load write with overwrite, or a control write, in a cycle where the counter would step. The first is provoked directly: after an enable, the bench counts ticks until the counter sits at zero, then issues the status write together with a tick. The flag must read back as set, and the interrupt must stay high. The random phase keeps ticks running while register writes land at arbitrary moments. Each cycle the bench compares the addressed word and the interrupt with its own model, which applies the write and discards the step in such cycles.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PRE_W   = 12;
    localparam int CTRL_W  = 26;
    localparam int SWR_BIT = 16;

    localparam int IDX_CTRL = 0;
    localparam int IDX_STAT = 1;
    localparam int IDX_LOAD = 2;
    localparam int IDX_CMP  = 3;
    localparam int IDX_CNT  = 4;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_FAST0 = 2'b01,
        SRC_FAST1 = 2'b10,
        SRC_SLOW  = 2'b11
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [5:0]       spare;
        logic             ovw;
        logic             swr;
        logic [PRE_W-1:0] pre;
        logic             rld;
        logic             ie;
        logic             keep;
        logic             en;
    } ctrl_t;
endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler
    import pdt_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] pre,
    output logic         step
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W-1:0] phase_d, phase_q;
    logic         at_end;

    always_comb begin
        at_end  = (phase_q >= pre);
        step    = run && !clr && tick && at_end;
        phase_d = phase_q;
        if (clr || !run) begin
            phase_d = '0;
        end else if (tick) begin
            phase_d = at_end ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    // R4: a stopped timer restarts its prescale phase
    assert_idle_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> phase_q == '0);

    // R4: with a prescale above zero, two steps never follow back to back
    assert_step_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && pre != '0) |=> (!step || pre == '0));
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         swr,
    input  logic         start_load,
    input  logic         ovw_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] load_val,
    input  logic         rld,
    output logic [W-1:0] cnt,
    output logic         expire
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] cnt_d, cnt_q;
    logic         at_zero;

    always_comb begin
        at_zero = (cnt_q == '0);
        expire  = step && at_zero && !swr;
        cnt_d   = cnt_q;
        if (swr) begin
            cnt_d = ALL_ONES;
        end else if (start_load) begin
            cnt_d = load_val;
        end else if (ovw_wr) begin
            cnt_d = wdata;
        end else if (step) begin
            if (at_zero) cnt_d = rld ? load_val : ALL_ONES;
            else         cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ALL_ONES;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R6: a plain step from a non-zero count decrements it
    assert_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_zero && !swr && !start_load && !ovw_wr)
        |=> cnt_q == $past(cnt_q) - 1'b1);

    // R6: an expiry in reload mode takes the load value
    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && rld && !start_load && !ovw_wr) |=> cnt_q == $past(load_val));

    // R7: an expiry in wrap mode goes to all ones
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !rld && !start_load && !ovw_wr) |=> cnt_q == ALL_ONES);

    // R3: without a step or a write the count holds
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !swr && !start_load && !ovw_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/pdt_regs.sv
module pdt_regs
    import pdt_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic [W-1:0]      load_val,
    output logic [W-1:0]      cmp_val,
    output logic              status,
    output logic              swr,
    output logic              start_load,
    output logic              ovw_wr
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] load;
        logic [W-1:0] cmp;
        logic         status;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl, wr_stat, wr_load, wr_cmp;
    ctrl_t ctrl_new;

    always_comb begin
        wr_ctrl  = wr && (addr == ADDR_W'(IDX_CTRL));
        wr_stat  = wr && (addr == ADDR_W'(IDX_STAT));
        wr_load  = wr && (addr == ADDR_W'(IDX_LOAD));
        wr_cmp   = wr && (addr == ADDR_W'(IDX_CMP));
        swr      = wr_ctrl && wdata[SWR_BIT];
        ctrl_new = ctrl_t'(wdata[CTRL_W-1:0]);
        ctrl_new.swr = 1'b0;

        r_d = r_q;
        if (swr) begin
            r_d.load = '1;
            r_d.cmp  = '0;
        end
        if (wr_ctrl) r_d.ctrl = ctrl_new;
        if (wr_load) r_d.load = wdata;
        if (wr_cmp)  r_d.cmp  = wdata;
        r_d.status = swr ? 1'b0 : (expire || (r_q.status && !wr_stat));

        start_load = wr_ctrl && ctrl_new.en && (ctrl_new.src != SRC_NONE) && !ctrl_new.keep;
        ovw_wr     = wr_load && r_q.ctrl.ovw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl   <= '0;
            r_q.load   <= '1;
            r_q.cmp    <= '0;
            r_q.status <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl     = r_q.ctrl;
    assign load_val = r_q.load;
    assign cmp_val  = r_q.cmp;
    assign status   = r_q.status;

    // R8: a status write with no expiry leaves the flag clear
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !expire) |=> !status);

    // R6: an expiry always leaves the flag set
    assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status);

    // R11: a software reset restores load and compare and never stores bit 16
    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> (load_val == '1 && cmp_val == '0 && !ctrl.swr && !status));
endmodule

// File: rtl/pdt_top.sv
module pdt_top
    import pdt_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic              irq
);
    timeunit 1ns;
    timeprecision 1ps;

    ctrl_t        ctrl;
    logic [W-1:0] load_val, cmp_val, cnt;
    logic         status, swr, start_load, ovw_wr, expire;
    logic         run, tick_sel, step;

    pdt_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .expire     (expire),
        .ctrl       (ctrl),
        .load_val   (load_val),
        .cmp_val    (cmp_val),
        .status     (status),
        .swr        (swr),
        .start_load (start_load),
        .ovw_wr     (ovw_wr)
    );

    always_comb begin
        run      = ctrl.en && (ctrl.src != SRC_NONE);
        tick_sel = (ctrl.src == SRC_SLOW) ? tick_slow : tick_fast;
    end

    pdt_prescaler #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (swr),
        .tick  (tick_sel),
        .pre   (ctrl.pre),
        .step  (step)
    );

    pdt_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .swr        (swr),
        .start_load (start_load),
        .ovw_wr     (ovw_wr),
        .wdata      (bus_wdata),
        .load_val   (load_val),
        .rld        (ctrl.rld),
        .cnt        (cnt),
        .expire     (expire)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(IDX_CTRL): bus_rdata = W'(ctrl);
            ADDR_W'(IDX_STAT): bus_rdata = W'(status);
            ADDR_W'(IDX_LOAD): bus_rdata = load_val;
            ADDR_W'(IDX_CMP):  bus_rdata = cmp_val;
            ADDR_W'(IDX_CNT):  bus_rdata = cnt;
            default:           bus_rdata = '0;
        endcase
        irq = status && ctrl.ie;
    end

    // R3: with no clock source the counter never steps
    assert_no_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.src == SRC_NONE) |-> !step);
endmodule

// File: tb/pdt_top_bench.sv
module pdt_top_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_ctrl = '0, m_load = ONES, m_cmp = '0, m_cnt = ONES;
    logic        m_st = 1'b0;
    logic [11:0] m_ph = '0;

    always #2.5 clk = ~clk;

    pdt_top u_pdt_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
    );

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return {31'b0, m_st};
            3'd2: return m_load;
            3'd3: return m_cmp;
            3'd4: return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    // Next-state model written from the requirements
    task automatic model(logic we, logic [2:0] a, logic [31:0] wd, logic tf, logic ts);
        logic run, tk, swr, step, expd;
        logic [31:0] nc, nl, ncmp, ncnt;
        logic ns;
        logic [11:0] nph;
        run  = m_ctrl[0] && (m_ctrl[25:24] != 2'b00);            // R3
        tk   = (m_ctrl[25:24] == 2'b11) ? ts : tf;
        swr  = we && a == 3'd0 && wd[16];
        step = run && tk && !swr && (m_ph >= m_ctrl[15:4]);      // R4
        expd = step && m_cnt == 32'h0;
        nph  = (swr || !run) ? 12'h0 : (tk ? ((m_ph >= m_ctrl[15:4]) ? 12'h0 : m_ph + 12'h1) : m_ph);
        nc = m_ctrl; nl = m_load; ncmp = m_cmp; ns = m_st; ncnt = m_cnt;
        if (step) ncnt = (m_cnt == 32'h0) ? (m_ctrl[3] ? m_load : ONES) : m_cnt - 32'h1;
        if (we) begin
            case (a)
                3'd0: begin
                    nc = wd & 32'h03FE_FFFF;
                    if (swr) begin nl = ONES; ncmp = '0; ns = 1'b0; ncnt = ONES; end  // R11
                    if (nc[0] && nc[25:24] != 2'b00 && !nc[1]) ncnt = nl;          // R5
                end
                3'd1: ns = 1'b0;
                3'd2: begin nl = wd; if (m_ctrl[17]) ncnt = wd; end               // R10
                3'd3: ncmp = wd;
                default: ;
            endcase
        end
        if (expd) ns = 1'b1;                                                       // R8
        m_ctrl = nc; m_load = nl; m_cmp = ncmp; m_st = ns; m_cnt = ncnt; m_ph = nph;
    endtask

    task automatic cyc(logic we, logic [2:0] a, logic [31:0] wd, logic tf, logic ts, string tag);
        bus_wr = we; bus_addr = a; bus_wdata = wd; tick_fast = tf; tick_slow = ts;
        model(we, a, wd, tf, ts);
        @(posedge clk);
        @(negedge clk);
        chk(tag, bus_rdata, exp_read(a));
        chk("R9", {31'b0, irq}, {31'b0, m_st && m_ctrl[2]});
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d, logic tf, string tag);
        cyc(1'b1, a, d, tf, 1'b0, tag);
    endtask

    task automatic rd(logic [2:0] a, logic tf, logic ts, string tag);
        cyc(1'b0, a, '0, tf, ts, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        for (int i = 0; i < 5; i++) rd(3'(i), 1'b0, 1'b0, "R1");
        // R2: map, masked control, read-only counter, unmapped words
        wr(3'd0, 32'hFFFE_FFF0, 1'b0, "R2");
        wr(3'd4, 32'h0000_0005, 1'b0, "R2");
        rd(3'd4, 1'b0, 1'b0, "R2");
        wr(3'd6, 32'h1234_5678, 1'b0, "R2");
        rd(3'd6, 1'b0, 1'b0, "R2");
        wr(3'd0, 32'h0, 1'b0, "R2");
        // R5: enable with keep 0 loads the counter
        wr(3'd2, 32'd9, 1'b0, "R5");
        wr(3'd0, 32'h0100_0001, 1'b0, "R5");
        rd(3'd4, 1'b1, 1'b0, "R3");
        rd(3'd4, 1'b1, 1'b0, "R3");
        // R3: source 00 holds, keep mode preserves count (R5)
        wr(3'd0, 32'h0000_0003, 1'b0, "R5");
        rd(3'd4, 1'b1, 1'b1, "R3");
        rd(3'd4, 1'b1, 1'b1, "R3");
        // R3: slow source ignores the fast tick
        wr(3'd0, 32'h0300_0003, 1'b0, "R5");
        rd(3'd4, 1'b1, 1'b0, "R3");
        rd(3'd4, 1'b0, 1'b1, "R3");
        // R4: prescale of 2 on the fast tick
        wr(3'd0, 32'h0200_0023, 1'b0, "R4");
        for (int i = 0; i < 9; i++) rd(3'd4, 1'b1, 1'b0, "R4");
        // R7: wrap to all ones, interrupt enabled (R9)
        wr(3'd2, 32'd2, 1'b0, "R7");
        wr(3'd0, 32'h0100_0005, 1'b0, "R7");
        for (int i = 0; i < 4; i++) rd(3'd4, 1'b1, 1'b0, "R7");
        rd(3'd1, 1'b0, 1'b0, "R9");
        // R8: status clear colliding with an expiry in reload mode (R6)
        wr(3'd1, 32'h0, 1'b0, "R8");
        wr(3'd2, 32'd3, 1'b0, "R6");
        wr(3'd0, 32'h0100_000D, 1'b0, "R6");
        for (int i = 0; i < 3; i++) rd(3'd4, 1'b1, 1'b0, "R6");
        wr(3'd1, 32'h0, 1'b1, "R8");
        rd(3'd1, 1'b0, 1'b0, "R8");
        rd(3'd4, 1'b0, 1'b0, "R6");
        wr(3'd1, 32'h1, 1'b0, "R8");
        // R10: overwrite on and off
        wr(3'd0, 32'h0102_000F, 1'b0, "R10");
        wr(3'd2, 32'd100, 1'b0, "R10");
        rd(3'd4, 1'b0, 1'b0, "R10");
        wr(3'd0, 32'h0100_000F, 1'b0, "R10");
        wr(3'd2, 32'd50, 1'b0, "R10");
        rd(3'd4, 1'b0, 1'b0, "R10");
        // R12: compare writes during counting
        wr(3'd3, 32'h0000_0062, 1'b1, "R12");
        rd(3'd4, 1'b1, 1'b0, "R12");
        wr(3'd3, 32'h0, 1'b1, "R12");
        rd(3'd3, 1'b1, 1'b0, "R12");
        // R11: software reset together with an enable
        wr(3'd0, 32'h0101_0005, 1'b1, "R11");
        for (int i = 0; i < 5; i++) rd(3'(i), 1'b0, 1'b0, "R11");
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic        we;
            logic [2:0]  a;
            logic [31:0] d;
            we = ($urandom % 8) == 0;
            a  = 3'($urandom % 8);
            d  = $urandom;
            if (we && a == 3'd0) begin
                d[16]    = ($urandom % 16) == 0;
                d[15:4]  = 12'($urandom % 4);
                d[31:26] = '0;
            end
            if (we && a == 3'd2) d = $urandom % 16;
            cyc(we, a, d, 1'($urandom % 2), 1'(($urandom % 4) == 0), "R6");
        end
        report();
        $finish;
    end
endmodule